// File: doc/BRIEF.md
# Privilege-Aware Status CSR Unit

This unit holds the status and control registers that a small three-level core consults on every privileged access. A single status word lives inside it. Two CSR addresses reach that word. The machine address reaches every implemented field. The supervisor address reads and writes only the supervisor fields, and the word's other bits pass through it untouched.

The unit also keeps:
- a supervisor scratch word,
- a read-only hart number,
- an address-translation control word, whose mode field goes straight out to the translation logic.

Each cycle the pipeline may present one CSR request: an operation, an address and write data. It may instead present a supervisor-return strobe. The unit answers in the same cycle with the read data and an illegal-instruction flag. Any state change lands on the next clock edge. The current privilege level is held here and is changed by a supervisor return.

Top module: `priv_csr_unit`

## Requirements
- R1: After reset the privilege output is machine level (encoding 3). The status, scratch and translation words are all zero, and the translation mode output is 0.
- R2: The machine address 0x300 and the supervisor address 0x100 reach one shared status word. A value written through either address is seen through the other, in every bit that both views expose.
- R3: A write through 0x100 changes only bits 1, 5, 8, 18 and 19 of the status word. Every other stored bit keeps its value, including the machine previous-privilege field at bits 12:11.
- R4: A read through 0x100 returns the stored bits 1, 5, 8, 18 and 19, and 0 in every other position, whatever is stored there.
- R5: Through 0x300, bits 1, 3, 5, 7, 8, 11, 12, 18 and 19 are writable. All other bits of the status word read as 0.
- R6: Address bits 9:8 give the lowest privilege allowed to access a register. A request from a lower level raises the illegal flag, returns 0 and changes no state. This covers 0x300 and the hart number at 0xF14 from supervisor or user level, and 0x100, 0x140 and 0x180 from user level.
- R7: A read of 0xF14 returns the hart number parameter. Any write to an address whose bits 11:10 are 3 raises the illegal flag.
- R8: Operation 2 on the scratch word at 0x140 is a swap. The old value is returned and the write data is stored on the same edge. Operation 0 only reads. Operation 1 stores the data and returns 0.
- R9: A legal write to the translation word at 0x180 shows its top 4 bits on the mode output right after the next clock edge.
- R10: A supervisor return from supervisor or machine level sets the privilege to status bit 8: 1 gives supervisor (1) and 0 gives user (0).
- R11: The same return clears bit 8, copies bit 5 into bit 1, and then sets bit 5 to 1.
- R12: A supervisor return issued at user level raises the illegal flag and leaves the privilege and all state unchanged.
- R13: An address that is not implemented, or operation code 3, raises the illegal flag with no state change. When a return and a request arrive in the same cycle, the return is carried out, the request is ignored, and the read data is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | A CSR request is presented this cycle |
| req_op_i | input | 2 | 0 read, 1 write, 2 swap, 3 reserved |
| req_addr_i | input | 12 | CSR address |
| req_wdata_i | input | XLEN | Write data |
| sret_valid_i | input | 1 | Supervisor-return instruction this cycle |
| rsp_rdata_o | output | XLEN | Read data (same cycle) |
| rsp_illegal_o | output | 1 | Illegal-instruction flag (same cycle) |
| priv_o | output | 2 | Current privilege level |
| satp_mode_o | output | MODE_W | Translation mode field |

## Verification
The bench first walks a directed path. It fills the status word with ones through the machine view, then clears it through the supervisor view. These two steps separate a shared store with masking from a store that ignores the mask or keeps two copies. Supervisor returns are then chained from machine to supervisor to user level. Each step checks that the privilege and the enable bits follow the stored previous-privilege bit, and not a fixed target. After that, random operations, addresses, data and returns are mixed at every privilege level, with resets scattered between them. This covers the cases where a legality rule could leak: a swap that also writes, a write to a read-only address, and a return issued together with a request.

// File: rtl/priv_csr_pkg.sv
package priv_csr_pkg;

    typedef enum logic [1:0] {
        PRIV_U = 2'd0,
        PRIV_S = 2'd1,
        PRIV_M = 2'd3
    } priv_e;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_SWAP  = 2'd2,
        OP_RSVD  = 2'd3
    } csr_op_e;

    localparam logic [11:0] ADDR_SVIEW   = 12'h100;
    localparam logic [11:0] ADDR_SSCR    = 12'h140;
    localparam logic [11:0] ADDR_XLATE   = 12'h180;
    localparam logic [11:0] ADDR_MVIEW   = 12'h300;
    localparam logic [11:0] ADDR_HARTNUM = 12'hF14;

    localparam int BIT_SIE  = 1;
    localparam int BIT_SPIE = 5;
    localparam int BIT_SPP  = 8;

    // supervisor-visible fields, and all implemented fields
    localparam logic [63:0] MASK_SVIEW = 64'h0000_0000_000C_0122;
    localparam logic [63:0] MASK_MVIEW = 64'h0000_0000_000C_19AA;

    typedef struct packed {
        logic mview;
        logic sview;
        logic sscr;
        logic xlate;
        logic hartnum;
    } csr_sel_t;

endpackage

// File: rtl/csr_gate.sv
module csr_gate
    import priv_csr_pkg::*;
(
    input  logic [1:0]  priv_i,
    input  logic        req_valid_i,
    input  csr_op_e     op_i,
    input  logic [11:0] addr_i,
    input  logic        sret_i,
    output csr_sel_t    sel_o,
    output logic        req_ok_o,
    output logic        sret_ok_o,
    output logic        wr_en_o,
    output logic        rd_en_o,
    output logic        illegal_o
);

    logic known;
    logic priv_ok;
    logic read_only;
    logic op_ok;
    logic req_legal;

    always_comb begin
        sel_o.mview   = (addr_i == ADDR_MVIEW);
        sel_o.sview   = (addr_i == ADDR_SVIEW);
        sel_o.sscr    = (addr_i == ADDR_SSCR);
        sel_o.xlate   = (addr_i == ADDR_XLATE);
        sel_o.hartnum = (addr_i == ADDR_HARTNUM);
        known     = |sel_o;
        priv_ok   = (priv_i >= addr_i[9:8]);
        read_only = (addr_i[11:10] == 2'b11);
        wr_en_o   = (op_i == OP_WRITE) || (op_i == OP_SWAP);
        rd_en_o   = (op_i == OP_READ) || (op_i == OP_SWAP);
        op_ok     = (op_i != OP_RSVD);
        req_legal = known && op_ok && priv_ok && !(wr_en_o && read_only);
        req_ok_o  = req_valid_i && !sret_i && req_legal;
        sret_ok_o = sret_i && (priv_i != PRIV_U);
        illegal_o = sret_i ? !sret_ok_o : (req_valid_i && !req_legal);
    end

endmodule

// File: rtl/status_view.sv
module status_view
    import priv_csr_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] stored_i,
    input  logic [XLEN-1:0] wdata_i,
    input  logic            sview_i,
    output logic [XLEN-1:0] rview_o,
    output logic [XLEN-1:0] wnext_o
);

    localparam logic [XLEN-1:0] SMASK = MASK_SVIEW[XLEN-1:0];
    localparam logic [XLEN-1:0] MMASK = MASK_MVIEW[XLEN-1:0];

    always_comb begin
        if (sview_i) begin
            rview_o = stored_i & SMASK;
            wnext_o = (stored_i & ~SMASK) | (wdata_i & SMASK);
        end else begin
            rview_o = stored_i & MMASK;
            wnext_o = wdata_i & MMASK;
        end
    end

endmodule

// File: rtl/priv_csr_unit.sv
module priv_csr_unit
    import priv_csr_pkg::*;
#(
    parameter int XLEN    = 64,
    parameter int MODE_W  = 4,
    parameter int HART_ID = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    input  logic [1:0]        req_op_i,
    input  logic [11:0]       req_addr_i,
    input  logic [XLEN-1:0]   req_wdata_i,
    input  logic              sret_valid_i,
    output logic [XLEN-1:0]   rsp_rdata_o,
    output logic              rsp_illegal_o,
    output logic [1:0]        priv_o,
    output logic [MODE_W-1:0] satp_mode_o
);

    localparam logic [XLEN-1:0] SMASK = MASK_SVIEW[XLEN-1:0];

    typedef struct packed {
        logic [XLEN-1:0] status;
        logic [XLEN-1:0] scratch;
        logic [XLEN-1:0] xlate;
        logic [1:0]      priv;
    } state_t;

    state_t st_d, st_q;

    csr_sel_t        sel;
    logic            req_ok, sret_ok, wr_en, rd_en;
    logic [XLEN-1:0] stat_rview, stat_wnext;

    csr_gate u_gate (
        .priv_i      (st_q.priv),
        .req_valid_i (req_valid_i),
        .op_i        (csr_op_e'(req_op_i)),
        .addr_i      (req_addr_i),
        .sret_i      (sret_valid_i),
        .sel_o       (sel),
        .req_ok_o    (req_ok),
        .sret_ok_o   (sret_ok),
        .wr_en_o     (wr_en),
        .rd_en_o     (rd_en),
        .illegal_o   (rsp_illegal_o)
    );

    status_view #(.XLEN(XLEN)) u_view (
        .stored_i (st_q.status),
        .wdata_i  (req_wdata_i),
        .sview_i  (sel.sview),
        .rview_o  (stat_rview),
        .wnext_o  (stat_wnext)
    );

    always_comb begin
        st_d        = st_q;
        rsp_rdata_o = '0;
        if (sret_ok) begin
            st_d.priv                 = {1'b0, st_q.status[BIT_SPP]};
            st_d.status[BIT_SPP]      = 1'b0;
            st_d.status[BIT_SIE]      = st_q.status[BIT_SPIE];
            st_d.status[BIT_SPIE]     = 1'b1;
        end else if (req_ok) begin
            if (rd_en) begin
                unique case (1'b1)
                    sel.mview, sel.sview: rsp_rdata_o = stat_rview;
                    sel.sscr:             rsp_rdata_o = st_q.scratch;
                    sel.xlate:            rsp_rdata_o = st_q.xlate;
                    sel.hartnum:          rsp_rdata_o = XLEN'(HART_ID);
                    default:              rsp_rdata_o = '0;
                endcase
            end
            if (wr_en) begin
                if (sel.mview || sel.sview) st_d.status  = stat_wnext;
                if (sel.sscr)               st_d.scratch = req_wdata_i;
                if (sel.xlate)              st_d.xlate   = req_wdata_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.priv <= PRIV_M;
        end else begin
            st_q <= st_d;
        end
    end

    assign priv_o      = st_q.priv;
    assign satp_mode_o = st_q.xlate[XLEN-1 -: MODE_W];

    AST_SVIEW_KEEPS_MPP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ok && wr_en && sel.sview) |=> $stable(st_q.status[12:11])); // R3

    AST_SVIEW_READ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && !sret_valid_i && req_addr_i == ADDR_SVIEW && !rsp_illegal_o)
        |-> ((rsp_rdata_o & ~SMASK) == '0)); // R4

    AST_LOW_PRIV_MACHINE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && !sret_valid_i && req_addr_i[9:8] == 2'b11 && priv_o != PRIV_M)
        |-> rsp_illegal_o); // R6

    AST_ILLEGAL_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_illegal_o |=> ($stable(st_q.status) && $stable(st_q.scratch)
                           && $stable(st_q.xlate) && $stable(priv_o))); // R6

    AST_XLATE_IMMEDIATE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ok && wr_en && sel.xlate)
        |=> (satp_mode_o == $past(req_wdata_i[XLEN-1 -: MODE_W]))); // R9

    AST_SRET_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        sret_ok |=> (priv_o == {1'b0, $past(st_q.status[BIT_SPP])})); // R10

    AST_SRET_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        sret_ok |=> (!st_q.status[BIT_SPP] && st_q.status[BIT_SPIE]
                     && st_q.status[BIT_SIE] == $past(st_q.status[BIT_SPIE]))); // R11

    AST_USER_SRET_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (sret_valid_i && priv_o == PRIV_U) |-> rsp_illegal_o); // R12

endmodule

// File: tb/sim_priv_csr_unit.sv
module sim_priv_csr_unit;

    localparam int XLEN = 64;
    localparam int MW   = 4;
    localparam int HART = 5;
    localparam logic [63:0] SM = 64'h000C_0122;
    localparam logic [63:0] MM = 64'h000C_19AA;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic            req_valid = 1'b0;
    logic [1:0]      req_op = '0;
    logic [11:0]     req_addr = '0;
    logic [XLEN-1:0] req_wdata = '0;
    logic            sret_valid = 1'b0;
    logic [XLEN-1:0] rsp_rdata;
    logic            rsp_illegal;
    logic [1:0]      priv;
    logic [MW-1:0]   satp_mode;

    priv_csr_unit #(.XLEN(XLEN), .MODE_W(MW), .HART_ID(HART)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_op_i(req_op),
        .req_addr_i(req_addr), .req_wdata_i(req_wdata), .sret_valid_i(sret_valid),
        .rsp_rdata_o(rsp_rdata), .rsp_illegal_o(rsp_illegal), .priv_o(priv),
        .satp_mode_o(satp_mode)
    );

    logic [63:0] m_status, m_scratch, m_xlate;
    logic [1:0]  m_priv;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    task automatic check(input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic bit known_addr(input logic [11:0] a);
        return a == 12'h300 || a == 12'h100 || a == 12'h140 ||
               a == 12'h180 || a == 12'hF14;
    endfunction

    function automatic bit legal_req(input logic [1:0] op, input logic [11:0] a);
        bit wr;
        wr = (op == 2'd1) || (op == 2'd2);
        return known_addr(a) && op != 2'd3 && m_priv >= a[9:8] &&
               !(wr && a[11:10] == 2'b11);
    endfunction

    function automatic logic [63:0] exp_read(input logic [1:0] op, input logic [11:0] a);
        if (op == 2'd1) return 64'd0;
        case (a)
            12'h300: return m_status & MM;
            12'h100: return m_status & SM;
            12'h140: return m_scratch;
            12'h180: return m_xlate;
            12'hF14: return 64'(HART);
            default: return 64'd0;
        endcase
    endfunction

    function automatic string tag_for(input bit s, input logic [1:0] op, input logic [11:0] a);
        if (s) return (m_priv == 2'd0) ? "R12" : "R10";
        if (!legal_req(op, a)) return known_addr(a) && op != 2'd3 ? "R6" : "R13";
        case (a)
            12'h300: return "R5";
            12'h100: return "R4";
            12'h140: return "R8";
            12'h180: return "R9";
            default: return "R7";
        endcase
    endfunction

    task automatic model_reset();
        m_status = '0; m_scratch = '0; m_xlate = '0; m_priv = 2'd3;
    endtask

    task automatic step(input string tag, input bit v, input logic [1:0] op,
                        input logic [11:0] a, input logic [63:0] w, input bit s);
        bit ill;
        logic [63:0] rd;
        @(negedge clk);
        req_valid = v; req_op = op; req_addr = a; req_wdata = w; sret_valid = s;
        #1;
        if (s) begin
            ill = (m_priv == 2'd0);
            rd  = '0;
        end else if (v) begin
            ill = !legal_req(op, a);
            rd  = ill ? 64'd0 : exp_read(op, a);
        end else begin
            ill = 1'b0;
            rd  = '0;
        end
        check(tag, "illegal", 64'(rsp_illegal), 64'(ill));
        check(tag, "rdata", rsp_rdata, rd);
        if (s && !ill) begin
            m_priv = {1'b0, m_status[8]};
            m_status[1] = m_status[5];
            m_status[5] = 1'b1;
            m_status[8] = 1'b0;
        end else if (!s && v && !ill && (op == 2'd1 || op == 2'd2)) begin
            case (a)
                12'h300: m_status = w & MM;
                12'h100: m_status = (m_status & ~SM) | (w & SM);
                12'h140: m_scratch = w;
                12'h180: m_xlate = w;
                default: ;
            endcase
        end
        @(posedge clk);
        #1;
        check(s ? "R10" : "R12", "priv", 64'(priv), 64'(m_priv));
        check("R9", "mode", 64'(satp_mode), 64'(m_xlate[63:60]));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; req_valid = 1'b0; sret_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        #1;
        check("R1", "priv after reset", 64'(priv), 64'd3);
        check("R1", "mode after reset", 64'(satp_mode), 64'd0);
    endtask

    initial begin
        logic [11:0] addrs [6];
        void'($urandom(32'd7741));
        addrs[0] = 12'h300; addrs[1] = 12'h100; addrs[2] = 12'h140;
        addrs[3] = 12'h180; addrs[4] = 12'hF14; addrs[5] = 12'h7C0;
        model_reset();
        do_reset();
        step("R1", 1, 2'd0, 12'h300, 0, 0);
        step("R1", 1, 2'd0, 12'h140, 0, 0);
        // R5 / R2 / R4: fill through machine view, read both views
        step("R5", 1, 2'd1, 12'h300, '1, 0);
        step("R5", 1, 2'd0, 12'h300, 0, 0);
        step("R2", 1, 2'd0, 12'h100, 0, 0);
        // R3: clear through supervisor view, machine bits remain
        step("R3", 1, 2'd1, 12'h100, 0, 0);
        step("R3", 1, 2'd0, 12'h300, 0, 0);
        // R7
        step("R7", 1, 2'd0, 12'hF14, 0, 0);
        step("R7", 1, 2'd1, 12'hF14, 64'h55, 0);
        step("R7", 1, 2'd2, 12'hF14, 64'h55, 0);
        // R8 swaps
        step("R8", 1, 2'd2, 12'h140, 64'hA5A5_0000_1234_5678, 0);
        step("R8", 1, 2'd2, 12'h140, 64'h0F0F_F0F0_0000_0001, 0);
        step("R8", 1, 2'd1, 12'h140, 64'h77, 0);
        step("R8", 1, 2'd0, 12'h140, 0, 0);
        // R9
        step("R9", 1, 2'd1, 12'h180, 64'h8000_0000_0000_0abc, 0);
        step("R9", 1, 2'd2, 12'h180, 64'h9000_0000_0000_0001, 0);
        // R2: supervisor write seen through machine view; set SPP=1, SPIE=1, SIE=0
        step("R2", 1, 2'd1, 12'h100, 64'h120, 0);
        step("R2", 1, 2'd0, 12'h300, 0, 0);
        // R10 / R11
        step("R10", 0, 2'd0, 12'h000, 0, 1);
        step("R11", 1, 2'd0, 12'h100, 0, 0);
        // R6 in supervisor
        step("R6", 1, 2'd0, 12'h300, 0, 0);
        step("R6", 1, 2'd1, 12'h300, '1, 0);
        step("R6", 1, 2'd0, 12'hF14, 0, 0);
        step("R6", 1, 2'd0, 12'h100, 0, 0);
        // R13: sret with request; return wins (SPP now 0 -> user)
        step("R13", 1, 2'd1, 12'h140, 64'hDEAD, 1);
        // R12 in user
        step("R12", 0, 2'd0, 12'h000, 0, 1);
        step("R6", 1, 2'd0, 12'h140, 0, 0);
        step("R6", 1, 2'd1, 12'h180, '1, 0);
        do_reset();
        step("R13", 1, 2'd0, 12'h7C0, 0, 0);
        step("R13", 1, 2'd3, 12'h140, 64'h1, 0);
        step("R8", 1, 2'd0, 12'h140, 0, 0);
        // random mix
        for (int i = 0; i < 3000; i++) begin
            bit s;
            logic [1:0] op;
            logic [11:0] a;
            logic [63:0] w;
            if ($urandom_range(0, 39) == 0) begin
                do_reset();
            end else begin
                s  = ($urandom_range(0, 9) == 0);
                op = 2'($urandom_range(0, 3));
                a  = addrs[$urandom_range(0, 5)];
                w  = {$urandom, $urandom};
                step(tag_for(s, op, a), 1, op, a, w, s);
            end
        end
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule